// File: doc/BRIEF.md
# Block-Entry Landing Checker

This block learns, from a streamed code image, which byte offsets are legal places to enter a basic block. A build opens with a start pulse. Instructions then arrive one per cycle, each with its byte offset. The block keeps a one-bit-per-halfword map in flip-flops. Offset zero is always marked. The offset just past every control-ending instruction is also marked. A done pulse closes the build.

After the build, two independent query ports look up target program counters in the map. The first port serves indirect jumps and raises a fatal-fault flag for an illegal target. The second port serves immediate jump and branch targets and raises an error flag. Each query subtracts the code base address from the target to form a code offset. An offset is legal only if it is even, lies below the code length seen in the build, and is marked in the map. A new build wipes every mark from the previous one.

Top module: `bb_landing_checker`

## Requirements
- R1: `busy_o` is high from reset and from the cycle after a build start until the cycle after build done. A query presented while `busy_o` is high gets no response.
- R2: After a build of nonzero length, a target equal to the code base (offset 0) passes.
- R3: An instruction whose bits [1:0] are not 2'b11 is 2 bytes long. Bits [1:0] = 2'b11 means 4 bytes. The code length and the marked position follow this size, whatever the upper 16 bits hold.
- R4: A 32-bit instruction is a terminator when its major opcode (bits [6:0]) is none of 0x03, 0x0F, 0x13, 0x17, 0x1B, 0x23, 0x33, 0x37, 0x3B. This covers branches, jal, jalr, system, the custom slots and atomics. The offset just past a terminator becomes marked.
- R5: Within the opcodes listed in R4, a 32-bit instruction is also a terminator when a register field it uses names x16 or above. The fields are rd (bit 11), rs1 (bit 19) and rs2 (bit 24). Opcodes 0x37 and 0x17 use rd. Opcodes 0x13, 0x1B and 0x03 use rd and rs1. Opcodes 0x33 and 0x3B use all three fields. Opcode 0x23 uses rs1 and rs2. Opcode 0x0F uses none.
- R6: A 16-bit instruction is a terminator in any of these cases, where funct3 is bits [15:13]:
  - bits [1:0] = 01 and funct3 is 101, 110 or 111;
  - bits [1:0] = 10 and funct3 is 001 or 101;
  - bits [1:0] = 10, funct3 is 100 and bits [6:2] = 0;
  - bits [1:0] = 00 and funct3 is 001, 100 or 101;
  - the whole halfword is zero.
- R7: An offset that follows a non-terminator, or that falls inside a 32-bit instruction, is unmarked. A query to it faults.
- R8: A target whose offset is odd faults.
- R9: A target whose offset is at or beyond the code length faults. This includes a target below the code base, which wraps to a large offset.
- R10: Each accepted query gets its response valid exactly one cycle later. The fault or error flag is high only together with response valid.
- R11: The branch-target port applies the same rule to the same map. It works independently of the jump port, including in the same cycle.
- R12: A build start clears all marks except offset 0 and resets the code length to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| build_start_i | input | 1 | Pulse that opens a new build |
| build_done_i | input | 1 | Pulse that closes the build |
| instr_valid_i | input | 1 | Instruction word valid during the build |
| instr_i | input | 32 | Instruction word; for a 16-bit instruction only bits [15:0] matter |
| instr_off_i | input | OFF_W | Byte offset of the instruction, even |
| busy_o | output | 1 | Queries refused |
| jmp_valid_i | input | 1 | Indirect-jump query valid |
| jmp_pc_i | input | 32 | Indirect-jump target PC |
| jmp_rsp_valid_o | output | 1 | Jump response valid |
| jmp_fault_o | output | 1 | Fatal fault: target is not a block start |
| br_valid_i | input | 1 | Immediate-target query valid |
| br_pc_i | input | 32 | Immediate jump/branch target PC |
| br_rsp_valid_o | output | 1 | Branch response valid |
| br_err_o | output | 1 | Target is not a block start |

## Verification
The jump port and the branch port can both fire in the same cycle and read the same map. The bench drives them together with matching targets, with different targets, and with one legal and one odd target. It then checks that each response follows only its own request. A build start can also arrive in the same cycle as an answered query. The bench provokes this and expects the query to be judged against the old map while the next cycle shows busy. A reference model kept in the bench, with a set of marked offsets and a length, predicts every output on every cycle.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BUILD, ST_READY} bld_state_e;

  localparam logic [6:0] OPC_LOAD     = 7'h03;
  localparam logic [6:0] OPC_MISC_MEM = 7'h0F;
  localparam logic [6:0] OPC_OP_IMM   = 7'h13;
  localparam logic [6:0] OPC_AUIPC    = 7'h17;
  localparam logic [6:0] OPC_OP_IMM32 = 7'h1B;
  localparam logic [6:0] OPC_STORE    = 7'h23;
  localparam logic [6:0] OPC_OP       = 7'h33;
  localparam logic [6:0] OPC_LUI      = 7'h37;
  localparam logic [6:0] OPC_OP32     = 7'h3B;
endpackage

// File: rtl/bb_term_decode.sv
module bb_term_decode
  import bb_pkg::*;
(
  input  logic [31:0] instr_i,
  output logic        len4_o,
  output logic        term_o
);
  logic       use_rd, use_rs1, use_rs2, plain_op;
  logic       term32, term16;
  logic [2:0] cf3;

  always_comb begin
    use_rd   = 1'b0;
    use_rs1  = 1'b0;
    use_rs2  = 1'b0;
    plain_op = 1'b1;
    case (instr_i[6:0])
      OPC_LUI, OPC_AUIPC:              use_rd = 1'b1;
      OPC_OP_IMM, OPC_OP_IMM32, OPC_LOAD: begin
        use_rd  = 1'b1;
        use_rs1 = 1'b1;
      end
      OPC_OP, OPC_OP32: begin
        use_rd  = 1'b1;
        use_rs1 = 1'b1;
        use_rs2 = 1'b1;
      end
      OPC_STORE: begin
        use_rs1 = 1'b1;
        use_rs2 = 1'b1;
      end
      OPC_MISC_MEM: ;
      default: plain_op = 1'b0;  // control flow, system, custom, unimplemented
    endcase
    term32 = !plain_op | (use_rd & instr_i[11]) | (use_rs1 & instr_i[19])
           | (use_rs2 & instr_i[24]);
  end

  always_comb begin
    cf3 = instr_i[15:13];
    case (instr_i[1:0])
      2'b00:   term16 = (instr_i[15:0] == 16'h0) | (cf3 == 3'b001)
                      | (cf3 == 3'b100) | (cf3 == 3'b101);
      2'b01:   term16 = (cf3 == 3'b101) | (cf3 == 3'b110) | (cf3 == 3'b111);
      2'b10:   term16 = (cf3 == 3'b001) | (cf3 == 3'b101)
                      | ((cf3 == 3'b100) && (instr_i[6:2] == 5'd0));
      default: term16 = 1'b0;
    endcase
  end

  assign len4_o = &instr_i[1:0];
  assign term_o = len4_o ? term32 : term16;
endmodule

// File: rtl/bb_target_check.sv
module bb_target_check #(
  parameter int          OFF_W     = 12,
  parameter int          LEN_W     = OFF_W + 1,
  parameter int          HW        = 2 ** (OFF_W - 1),
  parameter logic [31:0] CODE_BASE = 32'h0040_0000
) (
  input  logic [31:0]    pc_i,
  input  logic [LEN_W-1:0] code_len_i,
  input  logic [HW-1:0]  map_i,
  output logic           bad_o
);
  logic [31:0]      off;
  logic             in_range;
  logic [OFF_W-2:0] idx;

  assign off      = pc_i - CODE_BASE;
  assign in_range = off < 32'(code_len_i);
  assign idx      = off[OFF_W-1:1];
  // bounds first; map bit only consulted for in-range offsets
  assign bad_o    = off[0] | !in_range | !map_i[idx];
endmodule

// File: rtl/bb_landing_checker.sv
module bb_landing_checker
  import bb_pkg::*;
#(
  parameter int          CODE_BYTES = 4096,
  parameter logic [31:0] CODE_BASE  = 32'h0040_0000,
  parameter int          OFF_W      = $clog2(CODE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             build_start_i,
  input  logic             build_done_i,
  input  logic             instr_valid_i,
  input  logic [31:0]      instr_i,
  input  logic [OFF_W-1:0] instr_off_i,
  output logic             busy_o,
  input  logic             jmp_valid_i,
  input  logic [31:0]      jmp_pc_i,
  output logic             jmp_rsp_valid_o,
  output logic             jmp_fault_o,
  input  logic             br_valid_i,
  input  logic [31:0]      br_pc_i,
  output logic             br_rsp_valid_o,
  output logic             br_err_o
);
  localparam int LEN_W = OFF_W + 1;
  localparam int HW    = CODE_BYTES / 2;
  localparam int NQ    = 2;

  bld_state_e       state_q;
  logic [HW-1:0]    map_q;
  logic [LEN_W-1:0] len_q, next_end;
  logic             len4, term, accept, ready;

  logic [NQ-1:0]    q_valid, q_bad, rsp_q, flag_q;
  logic [31:0]      q_pc [NQ];

  bb_term_decode u_dec (
    .instr_i (instr_i),
    .len4_o  (len4),
    .term_o  (term)
  );

  assign ready    = (state_q == ST_READY);
  assign busy_o   = !ready;
  assign accept   = (state_q == ST_BUILD) && instr_valid_i;
  assign next_end = {1'b0, instr_off_i} + (len4 ? LEN_W'(4) : LEN_W'(2));

  assign q_valid = {br_valid_i, jmp_valid_i};
  assign q_pc[0] = jmp_pc_i;
  assign q_pc[1] = br_pc_i;

  for (genvar g = 0; g < NQ; g++) begin : g_q
    bb_target_check #(
      .OFF_W     (OFF_W),
      .LEN_W     (LEN_W),
      .HW        (HW),
      .CODE_BASE (CODE_BASE)
    ) u_chk (
      .pc_i       (q_pc[g]),
      .code_len_i (len_q),
      .map_i      (map_q),
      .bad_o      (q_bad[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rsp_q[g]  <= 1'b0;
        flag_q[g] <= 1'b0;
      end else begin
        rsp_q[g]  <= q_valid[g] && ready;
        flag_q[g] <= q_valid[g] && ready && q_bad[g];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      map_q   <= '0;
      len_q   <= '0;
    end else if (build_start_i) begin
      state_q <= ST_BUILD;
      map_q   <= HW'(1);  // offset 0 always a block start
      len_q   <= '0;
    end else begin
      if (accept) begin
        if (term && (next_end < LEN_W'(CODE_BYTES)))
          map_q[next_end[OFF_W-1:1]] <= 1'b1;
        if (next_end > len_q) len_q <= next_end;
      end
      if (build_done_i && (state_q == ST_BUILD)) state_q <= ST_READY;
    end
  end

  assign jmp_rsp_valid_o = rsp_q[0];
  assign jmp_fault_o     = flag_q[0];
  assign br_rsp_valid_o  = rsp_q[1];
  assign br_err_o        = flag_q[1];
endmodule

// File: rtl/bb_landing_checker_sva.sv
module bb_landing_checker_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        build_start_i,
  input logic        busy_o,
  input logic        jmp_valid_i,
  input logic [31:0] jmp_pc_i,
  input logic        jmp_rsp_valid_o,
  input logic        jmp_fault_o,
  input logic        br_valid_i,
  input logic [31:0] br_pc_i,
  input logic        br_rsp_valid_o,
  input logic        br_err_o
);
  AST_NO_RSP_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jmp_rsp_valid_o |-> $past(jmp_valid_i && !busy_o)); // R1
  AST_START_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    build_start_i |=> busy_o); // R1
  AST_JMP_RSP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jmp_valid_i && !busy_o) |=> jmp_rsp_valid_o); // R10
  AST_FAULT_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jmp_fault_o |-> jmp_rsp_valid_o); // R10
  AST_ODD_FAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jmp_valid_i && !busy_o && jmp_pc_i[0]) |=> jmp_fault_o); // R8
  AST_BR_RSP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_valid_i && !busy_o) |=> (br_rsp_valid_o && (br_err_o || !$past(br_pc_i[0])))); // R11
  AST_BR_ERR_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_err_o |-> br_rsp_valid_o); // R11
endmodule

bind bb_landing_checker bb_landing_checker_sva u_sva (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .build_start_i   (build_start_i),
  .busy_o          (busy_o),
  .jmp_valid_i     (jmp_valid_i),
  .jmp_pc_i        (jmp_pc_i),
  .jmp_rsp_valid_o (jmp_rsp_valid_o),
  .jmp_fault_o     (jmp_fault_o),
  .br_valid_i      (br_valid_i),
  .br_pc_i         (br_pc_i),
  .br_rsp_valid_o  (br_rsp_valid_o),
  .br_err_o        (br_err_o)
);

// File: tb/sim_bb_landing_checker.sv
module sim_bb_landing_checker;
  localparam int          CLK_PERIOD = 10;
  localparam int          CODE_BYTES = 4096;
  localparam int          OFF_W      = $clog2(CODE_BYTES);
  localparam logic [31:0] BASE       = 32'h0040_0000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic build_start_i = 0, build_done_i = 0, instr_valid_i = 0;
  logic [31:0] instr_i = '0;
  logic [OFF_W-1:0] instr_off_i = '0;
  logic jmp_valid_i = 0, br_valid_i = 0;
  logic [31:0] jmp_pc_i = '0, br_pc_i = '0;
  logic busy_o, jmp_rsp_valid_o, jmp_fault_o, br_rsp_valid_o, br_err_o;

  bb_landing_checker #(.CODE_BYTES(CODE_BYTES), .CODE_BASE(BASE)) u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0, fails = 0, cycles = 0, pos = 0;
  string cur_req = "R1";
  string tag_at [int];

  // behavioural reference: set of marked offsets, length, phase
  bit marks [int];
  int m_len = 0, m_phase = 0;  // 0 idle, 1 building, 2 ready
  bit ex_jv = 0, ex_jf = 0, ex_bv = 0, ex_be = 0;
  int m_end;
  bit started = 0;

  function automatic bit ref_term(logic [31:0] w);
    if (w[1:0] == 2'b11) begin
      case (w[6:0])
        7'h37, 7'h17:        return w[11];
        7'h13, 7'h1B, 7'h03: return w[11] | w[19];
        7'h33, 7'h3B:        return w[11] | w[19] | w[24];
        7'h23:               return w[19] | w[24];
        7'h0F:               return 1'b0;
        default:             return 1'b1;
      endcase
    end
    if (w[15:0] == 16'h0) return 1'b1;
    if (w[1:0] == 2'b01) return w[15:13] inside {3'b101, 3'b110, 3'b111};
    if (w[1:0] == 2'b10)
      return (w[15:13] inside {3'b001, 3'b101}) || (w[15:13] == 3'b100 && w[6:2] == 0);
    return w[15:13] inside {3'b001, 3'b100, 3'b101};
  endfunction

  function automatic bit ref_bad(logic [31:0] pc);
    logic [31:0] o;
    o = pc - BASE;
    return o[0] || (o >= 32'(m_len)) || !marks.exists(int'(o));
  endfunction

  always @(posedge clk_i) begin
    cycles++;
    if (!rst_ni) begin
      m_phase = 0; m_len = 0; marks.delete();
      ex_jv = 0; ex_jf = 0; ex_bv = 0; ex_be = 0;
    end else begin
      ex_jv = jmp_valid_i && m_phase == 2;
      ex_jf = ex_jv && ref_bad(jmp_pc_i);
      ex_bv = br_valid_i && m_phase == 2;
      ex_be = ex_bv && ref_bad(br_pc_i);
      if (build_start_i) begin
        m_phase = 1; m_len = 0; marks.delete(); marks[0] = 1;
      end else begin
        if (m_phase == 1 && instr_valid_i) begin
          m_end = int'(instr_off_i) + ((instr_i[1:0] == 2'b11) ? 4 : 2);
          if (ref_term(instr_i) && m_end < CODE_BYTES) marks[m_end] = 1;
          if (m_end > m_len) m_len = m_end;
        end
        if (build_done_i && m_phase == 1) m_phase = 2;
      end
    end
  end

  task automatic chk(input bit got, input bit exp, input string what, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b at t=%0t", req, what, got, exp, $time);
    end
  endtask

  // every cycle, away from the active edge (R10 timing, R1 busy)
  always @(negedge clk_i) if (started) begin
    chk(busy_o, m_phase != 2, "busy", "R1");
    chk(jmp_rsp_valid_o, ex_jv, "jmp_rsp_valid", "R10");
    chk(jmp_fault_o, ex_jf, "jmp_fault", cur_req);
    chk(br_rsp_valid_o, ex_bv, "br_rsp_valid", "R11");
    chk(br_err_o, ex_be, "br_err", cur_req);
  end

  always @(posedge clk_i) if (cycles > 20000) begin
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic start_build();
    build_start_i = 1; @(negedge clk_i); build_start_i = 0; pos = 0; tag_at.delete();
  endtask
  task automatic finish_build();
    build_done_i = 1; @(negedge clk_i); build_done_i = 0;
  endtask
  task automatic feed(input logic [31:0] w, input string next_tag);
    instr_valid_i = 1; instr_i = w; instr_off_i = OFF_W'(pos);
    @(negedge clk_i);
    instr_valid_i = 0;
    pos += (w[1:0] == 2'b11) ? 4 : 2;
    tag_at[pos] = next_tag;
  endtask
  task automatic jq(input logic [31:0] pc);
    jmp_valid_i = 1; jmp_pc_i = pc; @(negedge clk_i); jmp_valid_i = 0;
  endtask
  task automatic both(input logic [31:0] pj, input logic [31:0] pb);
    jmp_valid_i = 1; jmp_pc_i = pj; br_valid_i = 1; br_pc_i = pb;
    @(negedge clk_i); jmp_valid_i = 0; br_valid_i = 0;
  endtask

  function automatic string tag_for(int o);
    if (o == 0) return "R2";
    if (o % 2) return "R8";
    if (o >= m_len) return "R9";
    if (tag_at.exists(o)) return tag_at[o];
    return "R7";
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1; started = 1;
    @(negedge clk_i);
    cur_req = "R1"; jq(BASE); both(BASE, BASE); @(negedge clk_i);

    start_build();
    feed(32'h00100093, "R7");  // addi: plain
    feed(32'h00208063, "R4");  // beq
    feed(32'hFFFF0085, "R3");  // 16-bit addi, junk upper half
    feed(32'h0000A001, "R6");  // c.j
    feed(32'h00008067, "R4");  // jalr
    feed(32'h0000400B, "R4");  // custom fallthrough
    feed(32'h00208833, "R5");  // add x16
    feed(32'h0FF0000F, "R7");  // fence
    feed(32'h00008082, "R6");  // c.jr
    feed(32'h0000C001, "R6");  // c.beqz
    feed(32'h00000073, "R4");  // ecall
    feed(32'h00000000, "R6");  // zero halfword
    feed(32'h0000808A, "R3");  // c.mv
    feed(32'h000010B7, "R7");  // lui
    feed(32'h0000202F, "R4");  // atomic
    feed(32'h00002000, "R6");  // compressed fp load
    feed(32'h00088093, "R5");  // addi rs1=x17
    feed(32'h0100A023, "R5");  // sw rs2=x16
    feed(32'h00000085, "R3");
    cur_req = "R1"; jq(BASE + 8);  // still building
    finish_build();

    for (int o = 0; o < 66; o++) begin
      cur_req = tag_for(o); jq(BASE + 32'(o));
    end
    cur_req = "R9"; jq(BASE - 2); jq(BASE + 32'd4000);

    cur_req = "R11";
    both(BASE + 8, BASE + 8);
    both(BASE + 12, BASE + 10);
    both(BASE + 3, BASE + 30);
    both(BASE + 2, BASE - 4);
    for (int o = 0; o < 62; o += 2) begin
      br_valid_i = 1; br_pc_i = BASE + 32'(o); @(negedge clk_i); br_valid_i = 0;
    end
    cur_req = "R10"; jq(BASE + 8); jq(BASE + 10); jq(BASE + 12);

    // rebuild with a query in the same cycle as the start
    cur_req = "R12";
    jmp_valid_i = 1; jmp_pc_i = BASE + 8; start_build(); jmp_valid_i = 0;
    feed(32'h00000085, "R3");
    feed(32'h00000085, "R3");
    feed(32'h00100093, "R12");
    feed(32'h00100093, "R12");
    feed(32'h0000006F, "R4");  // jal
    feed(32'h00100093, "R12");
    feed(32'h00100093, "R12");
    feed(32'h00100093, "R12");
    finish_build();
    for (int o = 0; o < 32; o += 2) begin
      cur_req = tag_for(o); jq(BASE + 32'(o));
    end
    cur_req = "R12"; both(BASE + 24, BASE + 16);
    repeat (2) @(negedge clk_i);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule